// File: doc/BRIEF.md
# Hybrid Priority / Round-Robin Bus Arbiter

This block decides which of several bus masters may drive a shared high-performance bus. Each master raises a request line and receives a one-hot grant. A mode input chooses between two schemes at run time. In fixed-priority mode every master carries a static 2-bit priority from a configuration input, and the highest-priority requester wins. Requesters that tie at that level are served in rotation. In round-robin mode priorities are ignored: masters are served in circular order, and no owner may keep the bus beyond a bounded slice of cycles.

The control is a two-state machine. In `ARB_IDLE` no grant is driven. The *claim* transition to `ARB_OWNED` happens on the first clock edge at which any request is present. In `ARB_OWNED` the current owner keeps the bus (*hold*) until its tenure ends. Tenure ends when the owner drops its request, pulses its release line, or, in round-robin mode only, uses up its slice. At that edge the arbiter either passes the grant to the next winner (*handover*, staying in `ARB_OWNED`) or returns to `ARB_IDLE` (*drain*) when nobody is requesting.

Rotation uses two kinds of pointer: one global pointer for round-robin mode and one pointer per priority level for tie-breaking. Every new grant moves both the global pointer and the pointer of the winner's level to the position just after the winner.

Top module: `prio_rr_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every grant and sets all rotation pointers to master 0, so the first arbitration after reset among equal candidates goes to master 0.
- R2: At most one grant bit is set in any cycle, and the grant is zero in the cycle after a cycle with no request.
- R3: In fixed-priority mode (mode input 0), the master priority sits in bits [2i+1:2i] of the configuration input, and a larger value means higher priority. A new grant always goes to a requesting master whose priority equals the largest priority among the requesters.
- R4: In fixed-priority mode, requesters tied at the winning level are chosen by scanning upward (with wrap) from that level's pointer. The pointer then moves to the master just after the winner, so tied masters are served in turn.
- R5: In round-robin mode (mode input 1), the winner is the first requester found scanning upward (with wrap) from the global pointer, which moves to the master just after each winner. Non-requesting masters are skipped.
- R6: In round-robin mode an owner holds the grant for at most SLICE_CYCLES consecutive cycles and is then replaced by the next requester. If the owner is the only requester, it is granted again with a fresh slice.
- R7: An owner that drops its request, or pulses its release line, loses the grant at the next clock edge, and the next winner is chosen at that same edge.
- R8: In fixed-priority mode the grant never changes while the owner keeps requesting and does not release. No slice limit applies in this mode.
- R9: From the idle state, a request leads to a grant on the very next clock edge.
- R10: In round-robin mode with every master requesting continuously, each master is granted at least once in every window of N_MASTERS*SLICE_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_rr | input | 1 | 0 selects fixed priority, 1 selects round-robin |
| prio_cfg | input | N_MASTERS*PRIO_W | Static priority of each master, PRIO_W bits per master |
| req | input | N_MASTERS | Per-master bus request |
| rel_done | input | N_MASTERS | Per-master release pulse, ending the owner's tenure |
| gnt | output | N_MASTERS | One-hot (or zero) registered grant |

## Verification
The bench builds the arbiter with its defaults: four masters, 2-bit priorities and an 8-cycle slice. With these values every priority configuration (256) can be crossed with every non-zero request pattern (15), starting from idle, and the winner can be checked against the arithmetic maximum and the rotation pointers. The short slice lets full rotations, slice expiry, sole-requester re-grants and the starvation window of 32 cycles all be reached within a few hundred cycles. A pseudo-random phase that mixes modes, releases and priorities covers the mode switch while a fixed-mode owner holds a saturated slice count.

// File: rtl/prio_rr_arb_pkg.sv
`timescale 1ns/1ps
package prio_rr_arb_pkg;

    // Control states of the arbiter.
    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;

endpackage

// File: rtl/arb_rot_pick.sv
`timescale 1ns/1ps
// Rotating first-set picker: scans mask upward from ptr with wrap-around.
module arb_rot_pick #(
    parameter int N_MASTERS = 4,
    parameter int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] mask,
    input  logic [IDX_W-1:0]     ptr,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N_MASTERS; k++) begin
            int               pos;
            logic [IDX_W-1:0] cand;
            pos = int'(ptr) + k;
            if (pos >= N_MASTERS) begin
                pos = pos - N_MASTERS;
            end
            cand = IDX_W'(pos);
            if (!found && mask[cand]) begin
                found = 1'b1;
                idx   = cand;
            end
        end
    end

endmodule

// File: rtl/arb_top_level.sv
`timescale 1ns/1ps
// Finds the highest priority level among requesters and masks the rest.
module arb_top_level #(
    parameter int N_MASTERS = 4,
    parameter int PRIO_W    = 2
) (
    input  logic [N_MASTERS-1:0]        req,
    input  logic [N_MASTERS*PRIO_W-1:0] prio_cfg,
    output logic [N_MASTERS-1:0]        lvl_mask,
    output logic [PRIO_W-1:0]           top_lvl
);

    logic [PRIO_W-1:0] lvl_arr [N_MASTERS];

    for (genvar gi = 0; gi < N_MASTERS; gi++) begin : g_unpack
        assign lvl_arr[gi] = prio_cfg[gi*PRIO_W +: PRIO_W];
    end

    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (req[i] && (lvl_arr[i] > top_lvl)) begin
                top_lvl = lvl_arr[i];
            end
        end
    end

    for (genvar gm = 0; gm < N_MASTERS; gm++) begin : g_mask
        assign lvl_mask[gm] = req[gm] && (lvl_arr[gm] == top_lvl);
    end

endmodule

// File: rtl/arb_slice_timer.sv
`timescale 1ns/1ps
// Counts cycles of the current tenure, saturating at the last slice cycle.
module arb_slice_timer #(
    parameter int SLICE_CYCLES = 8,
    parameter int CNT_W        = (SLICE_CYCLES > 1) ? $clog2(SLICE_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLICE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);

endmodule

// File: rtl/prio_rr_arbiter.sv
`timescale 1ns/1ps
module prio_rr_arbiter
    import prio_rr_arb_pkg::*;
#(
    parameter int N_MASTERS    = 4,
    parameter int PRIO_W       = 2,
    parameter int SLICE_CYCLES = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        mode_rr,
    input  logic [N_MASTERS*PRIO_W-1:0] prio_cfg,
    input  logic [N_MASTERS-1:0]        req,
    input  logic [N_MASTERS-1:0]        rel_done,
    output logic [N_MASTERS-1:0]        gnt
);

    localparam int IDX_W  = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
    localparam int LEVELS = 1 << PRIO_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_MASTERS - 1);

    arb_state_e state_q, state_d;

    logic [IDX_W-1:0]     owner_q;
    logic [N_MASTERS-1:0] gnt_q;
    logic [IDX_W-1:0]     rr_ptr_q;
    logic [IDX_W-1:0]     lvl_ptr_q [LEVELS];

    logic [PRIO_W-1:0]    prio_arr [N_MASTERS];
    logic [N_MASTERS-1:0] lvl_mask;
    logic [PRIO_W-1:0]    top_lvl;
    logic                 fix_found, rr_found, win_found;
    logic [IDX_W-1:0]     fix_idx, rr_idx, win_idx, win_next;
    logic [PRIO_W-1:0]    win_lvl;
    logic [N_MASTERS-1:0] win_onehot;
    logic                 slice_expired;
    logic                 owner_ends;
    logic                 take;

    for (genvar gi = 0; gi < N_MASTERS; gi++) begin : g_prio
        assign prio_arr[gi] = prio_cfg[gi*PRIO_W +: PRIO_W];
    end

    arb_top_level #(
        .N_MASTERS (N_MASTERS),
        .PRIO_W    (PRIO_W)
    ) u_top_level (
        .req      (req),
        .prio_cfg (prio_cfg),
        .lvl_mask (lvl_mask),
        .top_lvl  (top_lvl)
    );

    // Fixed mode: rotate inside the winning level from that level's pointer.
    arb_rot_pick #(
        .N_MASTERS (N_MASTERS),
        .IDX_W     (IDX_W)
    ) u_pick_fixed (
        .mask  (lvl_mask),
        .ptr   (lvl_ptr_q[top_lvl]),
        .found (fix_found),
        .idx   (fix_idx)
    );

    // Round-robin mode: rotate over all requesters from the global pointer.
    arb_rot_pick #(
        .N_MASTERS (N_MASTERS),
        .IDX_W     (IDX_W)
    ) u_pick_rr (
        .mask  (req),
        .ptr   (rr_ptr_q),
        .found (rr_found),
        .idx   (rr_idx)
    );

    arb_slice_timer #(
        .SLICE_CYCLES (SLICE_CYCLES)
    ) u_slice (
        .clk     (clk),
        .rst     (rst),
        .restart (take),
        .expired (slice_expired)
    );

    always_comb begin
        win_found  = mode_rr ? rr_found : fix_found;
        win_idx    = mode_rr ? rr_idx   : fix_idx;
        win_lvl    = prio_arr[win_idx];
        win_next   = (win_idx == LAST_IDX) ? '0 : win_idx + 1'b1;
        win_onehot = '0;
        win_onehot[win_idx] = 1'b1;
        owner_ends = !req[owner_q] || rel_done[owner_q] ||
                     (mode_rr && slice_expired);
    end

    // Next-state and arbitration decision.
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (win_found) begin
                    state_d = ARB_OWNED;
                    take    = 1'b1;
                end
            end
            ARB_OWNED: begin
                if (owner_ends) begin
                    if (win_found) begin
                        take = 1'b1;
                    end else begin
                        state_d = ARB_IDLE;
                    end
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Grant, owner and rotation pointers.
    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q  <= '0;
            gnt_q    <= '0;
            rr_ptr_q <= '0;
            for (int l = 0; l < LEVELS; l++) begin
                lvl_ptr_q[l] <= '0;
            end
        end else if (take) begin
            owner_q            <= win_idx;
            gnt_q              <= win_onehot;
            rr_ptr_q           <= win_next;
            lvl_ptr_q[win_lvl] <= win_next;
        end else if (state_d == ARB_IDLE) begin
            gnt_q <= '0;
        end
    end

    assign gnt = gnt_q;

endmodule

// File: rtl/prio_rr_arbiter_chk.sv
`timescale 1ns/1ps
module prio_rr_arbiter_chk #(
    parameter int N_MASTERS    = 4,
    parameter int SLICE_CYCLES = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 mode_rr,
    input logic [N_MASTERS-1:0] req,
    input logic [N_MASTERS-1:0] rel,
    input logic [N_MASTERS-1:0] gnt
);

    logic [N_MASTERS-1:0] prev_gnt;
    int unsigned          wait_cnt;

    // Cycles an unchanged round-robin owner holds the bus while others wait.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_gnt <= '0;
            wait_cnt <= 0;
        end else begin
            prev_gnt <= gnt;
            if (mode_rr && (gnt != '0) && (gnt == prev_gnt) &&
                ((req & ~gnt) != '0)) begin
                wait_cnt <= wait_cnt + 1;
            end else begin
                wait_cnt <= 0;
            end
        end
    end

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> (gnt == '0));

    // R9
    claim_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt == '0) && (req != '0)) |=> (gnt != '0));

    // R3
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((gnt == $past(gnt)) || (gnt == '0) ||
                  ((gnt & $past(req)) != '0)));

    // R7
    drop_loses_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt & ~req) != '0) |=> ((gnt & $past(gnt)) == '0));

    // R7
    release_passes_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_rr && ((gnt & rel) != '0) && ((req & ~gnt) != '0))
            |=> (gnt != $past(gnt)));

    // R8
    fixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_rr && (gnt != '0) && ((gnt & req) == gnt) &&
         ((gnt & rel) == '0)) |=> (gnt == $past(gnt)));

    // R6
    slice_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= SLICE_CYCLES);

endmodule

bind prio_rr_arbiter prio_rr_arbiter_chk #(
    .N_MASTERS    (N_MASTERS),
    .SLICE_CYCLES (SLICE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_rr (mode_rr),
    .req     (req),
    .rel     (rel_done),
    .gnt     (gnt)
);

// File: tb/prio_rr_arbiter_bench.sv
`timescale 1ns/1ps
module prio_rr_arbiter_bench;

    localparam int N = 4;
    localparam int S = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_rr = 1'b0;
    logic [7:0]   prio_cfg = '0;
    logic [N-1:0] req = '0;
    logic [N-1:0] rel_done = '0;
    logic [N-1:0] gnt;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;

    // Reference state derived from the requirements.
    int m_owner = -1;
    int m_cnt   = 0;
    int m_rr    = 0;
    int m_lvl [4];

    prio_rr_arbiter #(
        .N_MASTERS    (N),
        .PRIO_W       (2),
        .SLICE_CYCLES (S)
    ) u_prio_rr_arbiter (
        .clk      (clk),
        .rst      (rst),
        .mode_rr  (mode_rr),
        .prio_cfg (prio_cfg),
        .req      (req),
        .rel_done (rel_done),
        .gnt      (gnt)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(150000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s cycle=%0d actual=%b expected=%b", tag, cyc, act, exp);
        end
    endtask

    function automatic int plev(input int i);
        return int'(prio_cfg[2*i +: 2]);
    endfunction

    function automatic int rot(input logic [N-1:0] mask, input int ptr);
        for (int k = 0; k < N; k++) begin
            int p;
            p = (ptr + k) % N;
            if (mask[p]) return p;
        end
        return -1;
    endfunction

    function automatic logic [N-1:0] m_vec();
        logic [N-1:0] v;
        v = '0;
        if (m_owner >= 0) v[m_owner] = 1'b1;
        return v;
    endfunction

    task automatic model_take();
        int w;
        if (mode_rr) begin
            w = rot(req, m_rr);
        end else begin
            int top;
            logic [N-1:0] mask;
            top = 0;
            for (int i = 0; i < N; i++) if (req[i] && plev(i) > top) top = plev(i);
            for (int i = 0; i < N; i++) mask[i] = req[i] && (plev(i) == top);
            w = rot(mask, m_lvl[top]);
        end
        m_owner = w;
        m_cnt   = 0;
        m_rr    = (w + 1) % N;
        m_lvl[plev(w)] = (w + 1) % N;
    endtask

    task automatic model_cycle();
        if (m_owner < 0) begin
            if (req != '0) model_take();
        end else if (!req[m_owner] || rel_done[m_owner] ||
                     (mode_rr && m_cnt == S - 1)) begin
            if (req != '0) model_take();
            else m_owner = -1;
        end else if (m_cnt < S - 1) begin
            m_cnt++;
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic [N-1:0] rl,
                        input logic m, input string tag);
        req      = r;
        rel_done = rl;
        mode_rr  = m;
        model_cycle();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        check(gnt == m_vec(), tag, gnt, m_vec());
        check($onehot0(gnt), "R2 single grant", gnt, m_vec());
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req = '0;
        rel_done = '0;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        check(gnt == '0, "R1 grant clear in reset", gnt, '0);
        m_owner = -1;
        m_cnt   = 0;
        m_rr    = 0;
        for (int l = 0; l < 4; l++) m_lvl[l] = 0;
        rst = 1'b0;
    endtask

    logic [15:0] lf = 16'hACE1;

    initial begin
        int runlen;
        int last [N];
        @(negedge clk);

        // R1: pointers at master 0 after reset
        prio_cfg = 8'h55;
        do_reset();
        step(4'hF, 4'h0, 1'b0, "R1 first fixed winner");
        check(gnt == 4'b0001, "R1 reset pointer fixed", gnt, 4'b0001);
        do_reset();
        step(4'hF, 4'h0, 1'b1, "R1 first rr winner");
        check(gnt == 4'b0001, "R1 reset pointer rr", gnt, 4'b0001);
        step(4'h0, 4'h0, 1'b1, "R2 drain to idle");
        check(gnt == '0, "R2 zero when idle", gnt, '0);

        // R3 R4 R9: every priority config crossed with every request pattern
        do_reset();
        for (int c = 0; c < 256; c++) begin
            prio_cfg = 8'(c);
            for (int r = 1; r < 16; r++) begin
                int g, top;
                step(4'(r), 4'h0, 1'b0, "R4 R9 fixed sweep winner");
                g = -1;
                for (int i = 0; i < N; i++) if (gnt[i]) g = i;
                top = 0;
                for (int i = 0; i < N; i++) if (r[i] && plev(i) > top) top = plev(i);
                check((g >= 0) && r[g] && (plev(g) == top),
                      "R3 highest priority wins", gnt, m_vec());
                step(4'h0, 4'h0, 1'b0, "R2 sweep idle");
            end
        end

        // R4: tied masters rotate 0,1,2,3 via release pulses
        prio_cfg = 8'hAA;
        do_reset();
        step(4'hF, 4'h0, 1'b0, "R4 tie start");
        for (int k = 1; k < 8; k++) begin
            logic [N-1:0] e;
            e = '0;
            e[k % N] = 1'b1;
            step(4'hF, gnt, 1'b0, "R4 tie rotation model");
            check(gnt == e, "R4 tie rotation order", gnt, e);
        end

        // R8: fixed owner never preempted, no slice limit
        prio_cfg = 8'b11_00_00_00;
        do_reset();
        for (int k = 0; k < 40; k++) begin
            step(4'hF, 4'h0, 1'b0, "R8 fixed hold model");
            check(gnt == 4'b1000, "R8 fixed owner kept", gnt, 4'b1000);
        end
        // mode switch with saturated slice count: immediate handover to master 0
        step(4'hF, 4'h0, 1'b1, "R6 switch to rr model");
        check(gnt == 4'b0001, "R6 expired slice after switch", gnt, 4'b0001);

        // R6 R10: all requesting in rr mode
        do_reset();
        runlen = 0;
        for (int i = 0; i < N; i++) last[i] = 0;
        for (int k = 1; k <= 4 * N * S; k++) begin
            step(4'hF, 4'h0, 1'b1, "R5 R10 rr model");
            if (gnt == 4'b0001 && k <= S + 1) runlen++;
            for (int i = 0; i < N; i++) begin
                if (gnt[i]) last[i] = k;
                check(k - last[i] <= N * S, "R10 no starvation", gnt, 4'(1 << i));
            end
        end
        check(runlen == S, "R6 slice length", 4'(runlen), 4'(S));

        // R6: sole requester is regranted indefinitely
        do_reset();
        for (int k = 0; k < 3 * S; k++) begin
            step(4'b0100, 4'h0, 1'b1, "R6 sole requester model");
            check(gnt == 4'b0100, "R6 sole requester kept", gnt, 4'b0100);
        end

        // R5: skip non-requesters (masters 1 and 3 only)
        do_reset();
        step(4'b1010, 4'h0, 1'b1, "R5 skip first");
        check(gnt == 4'b0010, "R5 skip to master 1", gnt, 4'b0010);
        step(4'b1010, 4'b0010, 1'b1, "R5 skip release");
        check(gnt == 4'b1000, "R5 skip to master 3", gnt, 4'b1000);
        step(4'b1010, 4'b1000, 1'b1, "R5 wrap release");
        check(gnt == 4'b0010, "R5 wrap to master 1", gnt, 4'b0010);

        // R7: early release and request drop
        do_reset();
        step(4'b0011, 4'h0, 1'b1, "R7 owner 0");
        step(4'b0011, 4'h0, 1'b1, "R7 hold");
        step(4'b0011, 4'b0001, 1'b1, "R7 release pulse");
        check(gnt == 4'b0010, "R7 release hands over", gnt, 4'b0010);
        step(4'b0001, 4'h0, 1'b1, "R7 drop request");
        check(gnt == 4'b0001, "R7 drop hands over", gnt, 4'b0001);

        // Mixed pseudo-random traffic, modes and priorities (R5 R6 R7 R8)
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] r, rl;
            logic m;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            r  = lf[3:0] | lf[7:4];
            rl = lf[11:8] & lf[15:12] & lf[6:3];
            m  = (k / 500) % 2 == 1;
            if (k % 250 == 0) prio_cfg = lf[15:8];
            step(r, rl, m, "R5 R6 R7 R8 mixed traffic");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule